// File: doc/BRIEF.md
# Crossbar Slave-Port Priority Arbiter

This block sits in front of one slave port of a multi-master crossbar. Up to six masters raise requests toward the port, and the arbiter grants exactly one of them at a time. The grant steers a 32-bit address and write-data select onto the slave side. Each master carries its own 3-bit priority value, set by software. Two designated masters, an I/O processor and the DMA engine, each have a sideband boost input. While the boost is high, that master competes at the top priority level.

The controller has two states. Idle means no transfer is in flight and the grant is parked on the last owner. Busy means the granted master owns the port until the slave signals the end of the current transfer.

The transitions are named as follows:
- Start (Idle to Busy): taken when any request is present.
- Park (Idle to Idle): taken when no master is requesting.
- Wait (Busy to Busy): taken while the transfer has not finished.
- Continue (Busy to Busy): taken at a transfer boundary when a request is pending. The owner may keep the port, or a stronger requester takes over on the same edge with no idle cycle.
- Release (Busy to Idle): taken at a boundary with no requests.

Top module: `xbar_slave_arb`

## Requirements
- R1: After reset the grant is parked on master 0 (grant = 6'b000001) and `s_active` is low.
- R2: The grant always has exactly one bit set.
- R3: Master i's priority is `m_prio[3*i +: 3]`, and a larger value wins. In Idle with any request, the grant moves on the next edge to the requester with the highest effective priority, and `s_active` rises.
- R4: Among requesters of equal effective priority that do not currently own a transfer, the lowest master index wins.
- R5: While Busy and `s_done` is low, the grant and `s_active` do not change, whatever the requests and boosts do.
- R6: When `s_done` is high in Busy, the owner keeps the grant if it is still requesting and its effective priority equals the highest among the requesters. `s_active` stays high.
- R7: When `s_done` is high in Busy and another requester wins, the grant moves to that requester on the same edge and `s_active` stays high.
- R8: When `s_done` is high in Busy with no requests, the state returns to Idle, `s_active` falls and the grant stays parked. In Idle with no requests, the grant holds, and `s_done` has no effect.
- R9: While `m_boost[0]` is high, master `BOOST_IOP_IDX` (default 1) has effective priority 7. While `m_boost[1]` is high, master `BOOST_DMA_IDX` (default 2) has effective priority 7. When a boost input is low, that master uses its programmed value.
- R10: `s_addr` and `s_wdata` equal the address and write data of the granted master: `m_addr[32*i +: 32]` and `m_wdata[32*i +: 32]`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| m_req | input | 6 | Per-master request |
| m_prio | input | 18 | Per-master 3-bit priority, master i at bits 3*i+2:3*i |
| m_boost | input | 2 | Boost for the I/O-processor master (bit 0) and the DMA master (bit 1) |
| m_addr | input | 192 | Per-master address, 32 bits each |
| m_wdata | input | 192 | Per-master write data, 32 bits each |
| s_done | input | 1 | Slave signals that the current transfer has finished |
| grant | output | 6 | Registered one-hot grant |
| s_active | output | 1 | A transfer is in flight (Busy) |
| s_addr | output | 32 | Address of the granted master |
| s_wdata | output | 32 | Write data of the granted master |

## Verification
`grant` and `s_active` are registered, so each one reflects the requests, boosts and `s_done` present at the previous rising edge. `s_addr` and `s_wdata` follow the grant combinationally in that same cycle. The driver applies each stimulus on a falling edge and pushes its expected result just after the next rising edge. The monitor compares that result on the following falling edge, which is exactly one edge after the stimulus. The master addresses and data stay constant, so the mux outputs depend only on the registered grant when they are sampled.

// File: rtl/xbar_arb_pkg.sv
package xbar_arb_pkg;
    typedef enum logic {
        ST_IDLE = 1'b0,
        ST_BUSY = 1'b1
    } arb_state_e;
endpackage

// File: rtl/xbar_arb_effprio.sv
module xbar_arb_effprio #(
    parameter int NUM_M         = 6,
    parameter int PRIO_W        = 3,
    parameter int BOOST_IOP_IDX = 1,
    parameter int BOOST_DMA_IDX = 2
) (
    input  logic [NUM_M*PRIO_W-1:0] prio_in,
    input  logic [1:0]              boost,
    output logic [NUM_M*PRIO_W-1:0] prio_eff
);
    localparam logic [PRIO_W-1:0] PRIO_MAX = {PRIO_W{1'b1}};

    for (genvar i = 0; i < NUM_M; i++) begin : g_eff
        if (i == BOOST_IOP_IDX) begin : g_iop
            assign prio_eff[i*PRIO_W +: PRIO_W] =
                boost[0] ? PRIO_MAX : prio_in[i*PRIO_W +: PRIO_W];
        end else if (i == BOOST_DMA_IDX) begin : g_dma
            assign prio_eff[i*PRIO_W +: PRIO_W] =
                boost[1] ? PRIO_MAX : prio_in[i*PRIO_W +: PRIO_W];
        end else begin : g_plain
            assign prio_eff[i*PRIO_W +: PRIO_W] = prio_in[i*PRIO_W +: PRIO_W];
        end
    end
endmodule

// File: rtl/xbar_arb_pick.sv
module xbar_arb_pick #(
    parameter int NUM_M  = 6,
    parameter int PRIO_W = 3
) (
    input  logic [NUM_M-1:0]        req,
    input  logic [NUM_M*PRIO_W-1:0] prio_eff,
    input  logic [NUM_M-1:0]        owner,
    output logic [NUM_M-1:0]        win,
    output logic                    any_req
);
    logic [PRIO_W-1:0] best;
    logic              found;
    logic              owner_ok;

    always_comb begin
        best = '0;
        for (int i = 0; i < NUM_M; i++) begin
            if (req[i] && prio_eff[i*PRIO_W +: PRIO_W] > best) begin
                best = prio_eff[i*PRIO_W +: PRIO_W];
            end
        end
    end

    always_comb begin
        owner_ok = 1'b0;
        for (int i = 0; i < NUM_M; i++) begin
            if (owner[i] && req[i] && prio_eff[i*PRIO_W +: PRIO_W] == best) begin
                owner_ok = 1'b1;
            end
        end
    end

    always_comb begin
        win   = '0;
        found = 1'b0;
        if (owner_ok) begin
            win = owner;
        end else begin
            for (int i = 0; i < NUM_M; i++) begin
                if (!found && req[i] && prio_eff[i*PRIO_W +: PRIO_W] == best) begin
                    win[i] = 1'b1;
                    found  = 1'b1;
                end
            end
        end
    end

    assign any_req = |req;
endmodule

// File: rtl/xbar_arb_mux.sv
module xbar_arb_mux #(
    parameter int NUM_M  = 6,
    parameter int ADDR_W = 32,
    parameter int DATA_W = 32
) (
    input  logic [NUM_M-1:0]        sel,
    input  logic [NUM_M*ADDR_W-1:0] addr_in,
    input  logic [NUM_M*DATA_W-1:0] data_in,
    output logic [ADDR_W-1:0]       addr_out,
    output logic [DATA_W-1:0]       data_out
);
    always_comb begin
        addr_out = '0;
        data_out = '0;
        for (int i = 0; i < NUM_M; i++) begin
            if (sel[i]) begin
                addr_out = addr_out | addr_in[i*ADDR_W +: ADDR_W];
                data_out = data_out | data_in[i*DATA_W +: DATA_W];
            end
        end
    end
endmodule

// File: rtl/xbar_slave_arb.sv
module xbar_slave_arb
    import xbar_arb_pkg::*;
#(
    parameter int NUM_M         = 6,
    parameter int PRIO_W        = 3,
    parameter int ADDR_W        = 32,
    parameter int DATA_W        = 32,
    parameter int BOOST_IOP_IDX = 1,
    parameter int BOOST_DMA_IDX = 2
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic [NUM_M-1:0]        m_req,
    input  logic [NUM_M*PRIO_W-1:0] m_prio,
    input  logic [1:0]              m_boost,
    input  logic [NUM_M*ADDR_W-1:0] m_addr,
    input  logic [NUM_M*DATA_W-1:0] m_wdata,
    input  logic                    s_done,
    output logic [NUM_M-1:0]        grant,
    output logic                    s_active,
    output logic [ADDR_W-1:0]       s_addr,
    output logic [DATA_W-1:0]       s_wdata
);
    localparam logic [NUM_M-1:0] GRANT_RST = NUM_M'(1);

    arb_state_e               state_q, state_d;
    logic [NUM_M-1:0]         grant_q, grant_d;
    logic [NUM_M*PRIO_W-1:0]  prio_eff;
    logic [NUM_M-1:0]         owner_mask;
    logic [NUM_M-1:0]         win;
    logic                     any_req;

    xbar_arb_effprio #(
        .NUM_M(NUM_M), .PRIO_W(PRIO_W),
        .BOOST_IOP_IDX(BOOST_IOP_IDX), .BOOST_DMA_IDX(BOOST_DMA_IDX)
    ) u_eff (
        .prio_in (m_prio),
        .boost   (m_boost),
        .prio_eff(prio_eff)
    );

    // Incumbent preference only applies at a boundary of an active transfer.
    assign owner_mask = (state_q == ST_BUSY) ? grant_q : '0;

    xbar_arb_pick #(.NUM_M(NUM_M), .PRIO_W(PRIO_W)) u_pick (
        .req     (m_req),
        .prio_eff(prio_eff),
        .owner   (owner_mask),
        .win     (win),
        .any_req (any_req)
    );

    xbar_arb_mux #(.NUM_M(NUM_M), .ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_mux (
        .sel     (grant_q),
        .addr_in (m_addr),
        .data_in (m_wdata),
        .addr_out(s_addr),
        .data_out(s_wdata)
    );

    // Next-state logic
    always_comb begin
        state_d = state_q;
        grant_d = grant_q;
        unique case (state_q)
            ST_IDLE: begin
                if (any_req) begin            // Start
                    state_d = ST_BUSY;
                    grant_d = win;
                end                           // else Park
            end
            ST_BUSY: begin
                if (s_done) begin
                    if (any_req) begin        // Continue
                        grant_d = win;
                    end else begin            // Release
                        state_d = ST_IDLE;
                    end
                end                           // else Wait
            end
            default: begin
                state_d = ST_IDLE;
            end
        endcase
    end

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            grant_q <= GRANT_RST;
        end else begin
            state_q <= state_d;
            grant_q <= grant_d;
        end
    end

    // Outputs
    always_comb begin
        grant    = grant_q;
        s_active = (state_q == ST_BUSY);
    end

    assert_grant_onehot_R2: assert property (@(posedge clk) disable iff (!rst_n)
        $countones(grant) == 1);

    assert_start_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (!s_active && |m_req) |=> s_active);

    assert_win_requested_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (|m_req) |-> (|(win & m_req)));

    assert_no_midbeat_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (s_active && !s_done) |=> (s_active && $stable(grant)));

    assert_release_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (s_active && s_done && !(|m_req)) |=> (!s_active && $stable(grant)));

    assert_park_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (!s_active && !(|m_req)) |=> (!s_active && $stable(grant)));
endmodule

// File: tb/xbar_slave_arb_tb.sv
module xbar_slave_arb_tb;
    localparam int NM = 6;

    typedef struct {
        logic [NM-1:0] grant;
        logic          active;
        string         tag;
    } exp_t;

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic [NM-1:0]   m_req = '0;
    logic [NM*3-1:0] m_prio;
    logic [1:0]      m_boost = '0;
    logic [NM*32-1:0] m_addr;
    logic [NM*32-1:0] m_wdata;
    logic            s_done = 1'b0;
    logic [NM-1:0]   grant;
    logic            s_active;
    logic [31:0]     s_addr;
    logic [31:0]     s_wdata;

    int   n_run = 0;
    int   n_fail = 0;
    bit   drv_done = 1'b0;
    exp_t q[$];

    always #5 clk = ~clk;

    xbar_slave_arb u_dut (
        .clk(clk), .rst_n(rst_n), .m_req(m_req), .m_prio(m_prio),
        .m_boost(m_boost), .m_addr(m_addr), .m_wdata(m_wdata),
        .s_done(s_done), .grant(grant), .s_active(s_active),
        .s_addr(s_addr), .s_wdata(s_wdata)
    );

    function automatic logic [31:0] addr_of(int i);
        return 32'h4000_0000 | (i << 8);
    endfunction

    function automatic logic [31:0] data_of(int i);
        return 32'hD000_0000 | i;
    endfunction

    task automatic drive(input logic [NM-1:0] req, input logic done,
                         input logic [1:0] bst, input logic [NM-1:0] eg,
                         input logic ea, input string tag);
        exp_t e;
        @(negedge clk);
        m_req   = req;
        s_done  = done;
        m_boost = bst;
        @(posedge clk);
        e.grant  = eg;
        e.active = ea;
        e.tag    = tag;
        q.push_back(e);
    endtask

    // Monitor
    always @(negedge clk) begin
        if (q.size() > 0) begin
            exp_t e;
            logic [31:0] ea_addr, ea_data;
            e = q.pop_front();
            ea_addr = '0;
            ea_data = '0;
            for (int i = 0; i < NM; i++) begin
                if (e.grant[i]) begin
                    ea_addr = addr_of(i);
                    ea_data = data_of(i);
                end
            end
            n_run++;
            if (grant !== e.grant) begin
                n_fail++;
                $display("FAIL %s grant actual=%b expected=%b", e.tag, grant, e.grant);
            end
            n_run++;
            if (s_active !== e.active) begin
                n_fail++;
                $display("FAIL %s s_active actual=%b expected=%b", e.tag, s_active, e.active);
            end
            n_run++;
            if ($countones(grant) != 1) begin
                n_fail++;
                $display("FAIL R2 onehot actual=%b expected=one bit", grant);
            end
            n_run++;
            if (s_addr !== ea_addr || s_wdata !== ea_data) begin
                n_fail++;
                $display("FAIL R10 mux actual=%h/%h expected=%h/%h",
                         s_addr, s_wdata, ea_addr, ea_data);
            end
        end
    end

    initial begin
        for (int i = 0; i < NM; i++) begin
            m_addr[i*32 +: 32]  = addr_of(i);
            m_wdata[i*32 +: 32] = data_of(i);
        end
        // m5..m0 priorities: 0,5,5,3,2,1
        m_prio = {3'd0, 3'd5, 3'd5, 3'd3, 3'd2, 3'd1};
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;

        drive(6'b000000, 0, 2'b00, 6'b000001, 0, "R1");
        drive(6'b001101, 0, 2'b00, 6'b001000, 1, "R3");
        drive(6'b111101, 0, 2'b01, 6'b001000, 1, "R5");
        drive(6'b011000, 1, 2'b00, 6'b001000, 1, "R6");
        drive(6'b010000, 1, 2'b00, 6'b010000, 1, "R7");
        drive(6'b000000, 1, 2'b00, 6'b010000, 0, "R8");
        drive(6'b000000, 1, 2'b00, 6'b010000, 0, "R8");
        drive(6'b011000, 0, 2'b00, 6'b001000, 1, "R4");
        drive(6'b001010, 1, 2'b01, 6'b000010, 1, "R9");
        drive(6'b001100, 1, 2'b10, 6'b000100, 1, "R9");
        drive(6'b001100, 1, 2'b00, 6'b001000, 1, "R9");
        m_prio[2:0] = 3'd7;
        drive(6'b001001, 1, 2'b00, 6'b000001, 1, "R3");
        drive(6'b000011, 1, 2'b01, 6'b000001, 1, "R6");
        drive(6'b000000, 1, 2'b00, 6'b000001, 0, "R8");
        drive(6'b000110, 0, 2'b11, 6'b000010, 1, "R4");
        drive(6'b000100, 1, 2'b11, 6'b000100, 1, "R7");
        drive(6'b000000, 0, 2'b00, 6'b000100, 1, "R5");

        @(negedge clk);
        m_req  = '0;
        s_done = 1'b0;
        repeat (2) @(negedge clk);
        drv_done = 1'b1;
    end

    initial begin
        wait (drv_done);
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        #1000000;
        n_run++;
        n_fail++;
        $display("FAIL watchdog actual=timeout expected=completion");
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule